// File: doc/BRIEF.md
# Receive Character Queue with Fill-Level Trigger

This block sits between a serial receiver and the host side of a UART channel. Each received character is stored together with three error-status bits, such as parity, framing and break flags. The host drains the characters in arrival order. The head entry is always visible on the read port, and a read strobe removes it.

A level-reached output tells a host or DMA engine to come and collect a burst once the fill level reaches a threshold. The threshold is either one of four fixed levels or four times a programmed value. A non-zero programmed value wins over the fixed level. When queue mode is off, the block behaves as a one-character holding register with a threshold of one. A sticky flag records characters that were lost because no room was left.

Top module: `rxq_top`

## Requirements
- R1: After reset the queue is empty, the count is 0, and the overrun, level-reached and ready outputs are low. Queue mode starts disabled.
- R2: With queue mode enabled, up to 64 entries are held. They are read back in write order, each with its data byte and its 3 error bits unchanged.
- R3: A write arriving while the queue is full and no read is accepted in the same cycle is discarded. It sets the sticky overrun flag and leaves the count and the stored contents unchanged.
- R4: With queue mode enabled and a programmed value of 0, the level select picks the threshold: 0 gives 8, 1 gives 16, 2 gives 56, 3 gives 60.
- R5: A non-zero 4-bit programmed value N sets the threshold to 4×N, whatever the level select says.
- R6: The level-reached output is high exactly when the count is at or above the threshold. It falls once reads bring the count below the threshold.
- R7: With queue mode disabled, capacity is one character and the threshold is 1. A second write with no read in between is an overrun.
- R8: A clear strobe empties the queue and clears the overrun flag. It wins over a write in the same cycle.
- R9: A read while empty has no effect. While full, a read and a write in the same cycle are both accepted and the count stays the same.
- R10: Any change of the queue-mode input empties the queue.
- R11: The ready output is high exactly when at least one character is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear: empty the queue, drop the overrun flag |
| fifo_en_i | input | 1 | 1: 64-entry queue mode, 0: single holding register |
| lvl_sel_i | input | 2 | Fixed threshold select (8/16/56/60) |
| lvl_prog_i | input | 4 | Programmed threshold, 4×value when non-zero |
| wr_en_i | input | 1 | Write strobe from the receiver |
| wr_data_i | input | 8 | Received character |
| wr_err_i | input | 3 | Error-status bits of the character |
| rd_en_i | input | 1 | Host read strobe, removes the head entry |
| rd_data_o | output | 8 | Head entry data |
| rd_err_o | output | 3 | Head entry error bits |
| empty_o | output | 1 | No entry held |
| count_o | output | 7 | Number of entries held |
| rx_ready_o | output | 1 | At least one entry available |
| lvl_hit_o | output | 1 | Count at or above the threshold |
| overrun_o | output | 1 | Sticky: a character was discarded |

## Verification
The assertions take for granted that the configuration inputs and strobes change only between clock edges and are held at known values during reset. They also assume that the queue-mode input stays disabled across reset, so the mode-change detector starts in step with it. The stimulus keeps to this: every input is driven on the falling edge, and the mode is switched only after a full idle cycle. Reads on an empty queue and writes on a full one are issued on purpose, because the checks on ignored accesses depend on exactly those cases.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  localparam int DATA_W = 8;
  localparam int ERR_W  = 3;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic [ERR_W-1:0]  err;
  } rxq_entry_t;

  // Threshold in entries for the current configuration, clamped to depth.
  function automatic int unsigned rxq_trigger(logic en, logic [1:0] sel,
                                              int unsigned prog, int unsigned depth);
    int unsigned lvl;
    if (!en)            lvl = 1;
    else if (prog != 0) lvl = prog * 4;
    else begin
      case (sel)
        2'd0:    lvl = 8;
        2'd1:    lvl = 16;
        2'd2:    lvl = 56;
        default: lvl = 60;
      endcase
    end
    if (lvl > depth) lvl = depth;
    return lvl;
  endfunction

  // Circular pointer advance for any depth.
  function automatic int unsigned rxq_ptr_next(int unsigned ptr, int unsigned depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction

endpackage

// File: rtl/rxq_mem.sv
module rxq_mem
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  rxq_entry_t    wentry,
  input  logic [AW-1:0] raddr,
  output rxq_entry_t    rentry
);

  rxq_entry_t slot [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (we && (waddr == AW'(i))) slot[i] <= wentry;
    end
  end

  assign rentry = slot[raddr];

endmodule

// File: rtl/rxq_ctl.sv
module rxq_ctl
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          clr_ovr,
  input  logic          wr_req,
  input  logic          rd_req,
  input  logic [CW-1:0] cap,
  output logic          push_ok,
  output logic          pop_ok,
  output logic          drop,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [CW-1:0] count,
  output logic          overrun
);

  logic full, empty;

  assign full  = (count >= cap);
  assign empty = (count == '0);

  assign pop_ok  = rd_req & ~empty & ~flush;
  assign push_ok = wr_req & ~flush & (~full | pop_ok);
  assign drop    = wr_req & ~flush & full & ~pop_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= AW'(rxq_ptr_next(32'(wptr), DEPTH));
      if (pop_ok)  rptr <= AW'(rxq_ptr_next(32'(rptr), DEPTH));
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       overrun <= 1'b0;
    else if (clr_ovr) overrun <= 1'b0;
    else if (drop)    overrun <= 1'b1;
  end

endmodule

// File: rtl/rxq_trig.sv
module rxq_trig
  import rxq_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int CW     = $clog2(DEPTH + 1),
  parameter int PROG_W = 4
) (
  input  logic              fifo_en,
  input  logic [1:0]        sel,
  input  logic [PROG_W-1:0] prog,
  input  logic [CW-1:0]     count,
  output logic [CW-1:0]     trig_lvl,
  output logic              hit
);

  assign trig_lvl = CW'(rxq_trigger(fifo_en, sel, 32'(prog), DEPTH));
  assign hit      = (count >= trig_lvl);

endmodule

// File: rtl/rxq_top.sv
module rxq_top
  import rxq_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int PROG_W = 4,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              fifo_en_i,
  input  logic [1:0]        lvl_sel_i,
  input  logic [PROG_W-1:0] lvl_prog_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ERR_W-1:0]  wr_err_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [ERR_W-1:0]  rd_err_o,
  output logic              empty_o,
  output logic [CW-1:0]     count_o,
  output logic              rx_ready_o,
  output logic              lvl_hit_o,
  output logic              overrun_o
);

  localparam logic [CW-1:0] CAP_Q = CW'(DEPTH);
  localparam logic [CW-1:0] CAP_H = CW'(1);

  logic          prev_en;
  logic          mode_flip;
  logic          flush;
  logic [CW-1:0] cap;
  logic          push_ok, pop_ok, drop;
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic [CW-1:0] trig_lvl;
  rxq_entry_t    wentry, rentry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_en <= 1'b0;
    else        prev_en <= fifo_en_i;
  end

  assign mode_flip = fifo_en_i ^ prev_en;
  assign flush     = clr_i | mode_flip;
  assign cap       = fifo_en_i ? CAP_Q : CAP_H;

  assign wentry.data = wr_data_i;
  assign wentry.err  = wr_err_i;

  rxq_ctl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .clr_ovr (clr_i),
    .wr_req  (wr_en_i),
    .rd_req  (rd_en_i),
    .cap     (cap),
    .push_ok (push_ok),
    .pop_ok  (pop_ok),
    .drop    (drop),
    .wptr    (wptr),
    .rptr    (rptr),
    .count   (count),
    .overrun (overrun_o)
  );

  rxq_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk    (clk),
    .we     (push_ok),
    .waddr  (wptr),
    .wentry (wentry),
    .raddr  (rptr),
    .rentry (rentry)
  );

  rxq_trig #(.DEPTH(DEPTH), .CW(CW), .PROG_W(PROG_W)) u_trig (
    .fifo_en  (fifo_en_i),
    .sel      (lvl_sel_i),
    .prog     (lvl_prog_i),
    .count    (count),
    .trig_lvl (trig_lvl),
    .hit      (lvl_hit_o)
  );

  assign rd_data_o  = rentry.data;
  assign rd_err_o   = rentry.err;
  assign count_o    = count;
  assign empty_o    = (count == '0);
  assign rx_ready_o = ~empty_o;

endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
  parameter int DEPTH = 64,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr_i,
  input logic          fifo_en_i,
  input logic          wr_en_i,
  input logic          rd_en_i,
  input logic [CW-1:0] count_o,
  input logic          empty_o,
  input logic          rx_ready_o,
  input logic          lvl_hit_o,
  input logic          overrun_o,
  input logic          push_ok,
  input logic          pop_ok,
  input logic          drop
);

  // R2
  cap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_o <= CW'(DEPTH));

  // R2
  push_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && !pop_ok) |=> count_o == CW'($past(count_o) + 1'b1));

  // R3
  drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> overrun_o);

  // R3
  drop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> count_o == $past(count_o));

  // R7
  hold_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en_i && !$past(fifo_en_i)) |-> count_o <= CW'(1));

  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (count_o == '0) && !overrun_o);

  // R9
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && empty_o && !wr_en_i && !clr_i) |=> empty_o);

  // R6
  hit_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_hit_o |-> rx_ready_o);

endmodule

bind rxq_top rxq_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clr_i      (clr_i),
  .fifo_en_i  (fifo_en_i),
  .wr_en_i    (wr_en_i),
  .rd_en_i    (rd_en_i),
  .count_o    (count_o),
  .empty_o    (empty_o),
  .rx_ready_o (rx_ready_o),
  .lvl_hit_o  (lvl_hit_o),
  .overrun_o  (overrun_o),
  .push_ok    (push_ok),
  .pop_ok     (pop_ok),
  .drop       (drop)
);

// File: tb/tb_rxq_top.sv
module tb_rxq_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr_i = 1'b0;
  logic       fifo_en_i = 1'b0;
  logic [1:0] lvl_sel_i = 2'd0;
  logic [3:0] lvl_prog_i = 4'd0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = 8'd0;
  logic [2:0] wr_err_i = 3'd0;
  logic       rd_en_i = 1'b0;
  logic [7:0] rd_data_o;
  logic [2:0] rd_err_o;
  logic       empty_o;
  logic [6:0] count_o;
  logic       rx_ready_o;
  logic       lvl_hit_o;
  logic       overrun_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int m_count = 0;
  int m_cap   = 1;
  bit m_ovr   = 0;
  int seq     = 0;
  logic [10:0] sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rxq_top dut (.*);

  task automatic check_eq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_trig();
    if (!fifo_en_i) return 1;
    if (lvl_prog_i != 0) return 4 * lvl_prog_i;
    case (lvl_sel_i)
      2'd0: return 8;
      2'd1: return 16;
      2'd2: return 56;
      default: return 60;
    endcase
  endfunction

  task automatic check_state(string req);
    check_eq(req, "count", count_o, m_count);
    check_eq(req, "empty", empty_o, m_count == 0);
    check_eq(req, "ready", rx_ready_o, m_count != 0);
    check_eq(req, "overrun", overrun_o, m_ovr);
    check_eq(req, "level", lvl_hit_o, m_count >= exp_trig());
  endtask

  // Driver: one cycle of write and/or read, scoreboard updated from the model.
  task automatic drive(bit do_wr, bit do_rd);
    bit rd_hit, acc;
    logic [7:0] d;
    logic [2:0] e;
    d = seq[7:0] ^ 8'h5A;
    e = seq[2:0];
    if (do_wr) seq++;
    @(negedge clk);
    wr_en_i = do_wr; wr_data_i = d; wr_err_i = e; rd_en_i = do_rd;
    rd_hit = do_rd && (m_count > 0);
    acc    = do_wr && ((m_count < m_cap) || rd_hit);
    if (do_wr && !acc) m_ovr = 1;
    @(negedge clk);
    wr_en_i = 0; rd_en_i = 0;
    if (acc) sb_q.push_back({d, e});
    m_count = m_count + int'(acc) - int'(rd_hit);
  endtask

  task automatic clear_cycle(bit with_wr);
    @(negedge clk);
    clr_i = 1; wr_en_i = with_wr; wr_data_i = 8'hEE;
    @(negedge clk);
    clr_i = 0; wr_en_i = 0;
    m_count = 0; m_ovr = 0; sb_q.delete();
  endtask

  task automatic set_mode(bit en);
    @(negedge clk);
    fifo_en_i = en;
    @(negedge clk);
    m_count = 0; m_cap = en ? 64 : 1; sb_q.delete();
  endtask

  // Monitor: compares the head entry whenever a read is presented on a non-empty queue.
  always @(negedge clk) begin
    #1;
    if (rd_en_i && !empty_o) begin
      if (sb_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R2 unexpected data: actual %0d expected none", rd_data_o);
      end else begin
        logic [10:0] exp_e;
        exp_e = sb_q.pop_front();
        check_eq("R2", "read entry", {rd_data_o, rd_err_o}, exp_e);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_state("R1");

    // R7: holding register mode
    drive(1, 0);
    check_state("R7");
    check_state("R11");
    drive(1, 0);
    check_state("R7");
    check_eq("R3", "overrun after hold-mode overflow", overrun_o, 1);
    drive(0, 1);
    check_state("R7");

    // R8: clear drops overrun
    clear_cycle(0);
    check_state("R8");

    // queue mode, fixed levels (R4, R6)
    set_mode(1);
    check_state("R10");
    for (int i = 0; i < 7; i++) drive(1, 0);
    check_state("R4");
    drive(1, 0);
    check_state("R6");
    drive(0, 1);
    check_eq("R6", "level after read below trigger", lvl_hit_o, 0);
    @(negedge clk); lvl_sel_i = 2'd1; #1; check_state("R4");
    while (m_count < 16) drive(1, 0);
    check_state("R4");
    @(negedge clk); lvl_sel_i = 2'd2; #1; check_state("R4");
    while (m_count < 56) drive(1, 0);
    check_state("R4");
    @(negedge clk); lvl_sel_i = 2'd3; #1; check_state("R4");
    while (m_count < 60) drive(1, 0);
    check_state("R4");

    // R5: programmed level overrides
    @(negedge clk); lvl_sel_i = 2'd0; lvl_prog_i = 4'd15; #1; check_state("R5");
    while (m_count > 10) drive(0, 1);
    @(negedge clk); lvl_prog_i = 4'd5; #1;
    check_eq("R5", "level with prog 5 at count 10", lvl_hit_o, 0);
    check_state("R5");
    @(negedge clk); lvl_prog_i = 4'd2; #1; check_state("R5");

    // R3 and R9 at full
    while (m_count < 64) drive(1, 0);
    check_state("R2");
    drive(1, 0);
    check_state("R3");
    drive(1, 1);
    check_state("R9");
    while (m_count > 0) drive(0, 1);
    check_state("R2");
    drive(0, 1);
    check_state("R9");

    // R8: clear wins over a write
    for (int i = 0; i < 3; i++) drive(1, 0);
    clear_cycle(1);
    check_state("R8");

    // R10: mode change empties
    for (int i = 0; i < 5; i++) drive(1, 0);
    check_state("R2");
    set_mode(0);
    check_state("R10");
    drive(1, 0);
    drive(0, 1);
    check_state("R11");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule